// File: doc/BRIEF.md
# Sequential Leaky Integrate-and-Fire Neuron Core

This core advances a population of leaky integrate-and-fire neurons by one time step per tick. Each neuron owns a stored row holding a connectivity mask over the core's input lines, four selectable synaptic weights, a leak, a firing threshold and its membrane potential. Each input line carries a core-wide two-bit type that picks one of the four weights. This choice applies the same way to every neuron.

A tick strobe captures the input spike vector. The core then visits the neurons in ascending order and, for each neuron, the inputs in ascending order. It handles one synapse per clock and adds the chosen weight whenever both the mask bit and the captured spike bit are set. After the last input of a neuron, one extra clock subtracts the leak and compares the result with the threshold. In that same clock the core records the output spike and writes the potential back. Rows are loaded through a write port while the core is idle. Every write-back is also presented on an update port, together with the neuron index.

Top module: `snn_tile_core`

## Requirements
- R1: After reset, busy_o, done_o and upd_valid_o are low and spikes_o is all zero.
- R2: A tick_i high at a clock edge while idle captures spikes_in_i, clears spikes_o and raises busy_o. A tick_i while busy is ignored, and so is any change of spikes_in_i after the capture.
- R3: Each neuron takes N_INPUTS+1 clocks. Neuron n is written back, with upd_valid_o high for one cycle and upd_idx_o equal to n, exactly (n+1)*(N_INPUTS+1) edges after the capturing edge. done_o pulses together with the write-back of the last neuron, and busy_o falls in that same cycle.
- R4: Input j is active for a neuron when its mask bit j and captured spike bit j are both 1. Its weight type is axon_type_i[2j+1:2j]. Weight k sits at cfg_weights_i[9k+8:9k], is a two's complement 9-bit value, and is sign-extended before it is added.
- R5: Potential is signed 16-bit. Every addition and the leak subtraction saturate at +32767 and -32768 instead of wrapping.
- R6: The leak (signed 16-bit) is subtracted exactly once per neuron per tick, after all inputs, including for a neuron with no active input.
- R7: When the result is greater than or equal to the threshold (signed 16-bit), the neuron's bit in spikes_o is set and the stored potential becomes 0. Otherwise the bit stays 0 and the result is stored. The stored value seeds the next tick.
- R8: cfg_we_i while idle loads the row cfg_idx_i (mask, weights, leak, threshold, potential). A cfg_we_i while busy is ignored.
- R9: spikes_o holds its value from the end of a tick until the next accepted tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Tick strobe; starts a pass when idle |
| spikes_in_i | input | N_INPUTS | Input spike vector, captured on an accepted tick |
| axon_type_i | input | 2*N_INPUTS | Weight type per input line, 2 bits each |
| cfg_we_i | input | 1 | Row write enable (idle only) |
| cfg_idx_i | input | $clog2(N_NEURONS) | Row index to write |
| cfg_conn_i | input | N_INPUTS | Connectivity mask for the row |
| cfg_weights_i | input | 36 | Four 9-bit signed weights |
| cfg_leak_i | input | 16 | Signed leak |
| cfg_thr_i | input | 16 | Signed threshold |
| cfg_pot_i | input | 16 | Initial signed potential |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | One-cycle pulse at the end of a pass |
| spikes_o | output | N_NEURONS | Output spike vector of the current or last pass |
| upd_valid_o | output | 1 | A neuron's potential was just written back |
| upd_idx_o | output | $clog2(N_NEURONS) | Index of that neuron |
| upd_pot_o | output | 16 | Potential written back |

## Verification
Saturation is the hardest condition to reach from the ports, because a potential only nears a limit after many additions of large weights. The stimulus loads rows with start potentials a few counts from +32767 or -32768 and weights of +255 or -256 on every line, and then fires all inputs at once. Overflow then happens within the first few synapses, and the leak step runs on the clamped value. Ticks and row writes are also issued in the middle of a pass, and the input vector is changed at the same moment, so that the capture rule and the idle-only write rule are exercised.

// File: rtl/snn_tile_pkg.sv
package snn_tile_pkg;
  localparam int POT_W  = 16;
  localparam int WGT_W  = 9;
  localparam int N_WSEL = 4;
  localparam int WSEL_W = 2;

  typedef logic signed [POT_W-1:0] pot_t;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_ACC = 2'd1, ST_FIN = 2'd2} seq_st_e;

  function automatic pot_t clamp(input logic signed [POT_W+1:0] s);
    if (s > $signed({3'b000, {(POT_W-1){1'b1}}}))      return {1'b0, {(POT_W-1){1'b1}}};
    else if (s < $signed({3'b111, {(POT_W-1){1'b0}}})) return {1'b1, {(POT_W-1){1'b0}}};
    else                                               return s[POT_W-1:0];
  endfunction

  function automatic pot_t sat_add(input pot_t a, input pot_t b);
    logic signed [POT_W+1:0] ea, eb;
    ea = a;
    eb = b;
    return clamp(ea + eb);
  endfunction

  function automatic pot_t sat_sub(input pot_t a, input pot_t b);
    logic signed [POT_W+1:0] ea, eb;
    ea = a;
    eb = b;
    return clamp(ea - eb);
  endfunction
endpackage

// File: rtl/snn_param_store.sv
module snn_param_store
  import snn_tile_pkg::*;
#(
  parameter int N_NEURONS = 256,
  parameter int N_INPUTS  = 256,
  localparam int IDX_W = $clog2(N_NEURONS),
  localparam int WV_W  = N_WSEL * WGT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [IDX_W-1:0]    cfg_idx_i,
  input  logic [N_INPUTS-1:0] cfg_conn_i,
  input  logic [WV_W-1:0]     cfg_weights_i,
  input  pot_t                cfg_leak_i,
  input  pot_t                cfg_thr_i,
  input  pot_t                cfg_pot_i,
  input  logic                wb_en_i,
  input  logic [IDX_W-1:0]    wb_idx_i,
  input  pot_t                wb_pot_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic [N_INPUTS-1:0] rd_conn_o,
  output logic [WV_W-1:0]     rd_weights_o,
  output pot_t                rd_leak_o,
  output pot_t                rd_thr_o,
  output pot_t                rd_pot_o
);
  logic [N_INPUTS-1:0] conn_q [N_NEURONS];
  logic [WV_W-1:0]     wts_q  [N_NEURONS];
  pot_t                leak_q [N_NEURONS];
  pot_t                thr_q  [N_NEURONS];
  pot_t                pot_q  [N_NEURONS];

  for (genvar r = 0; r < N_NEURONS; r++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        conn_q[r] <= '0;
        wts_q[r]  <= '0;
        leak_q[r] <= '0;
        thr_q[r]  <= '0;
        pot_q[r]  <= '0;
      end else if (cfg_we_i && cfg_idx_i == IDX_W'(r)) begin
        conn_q[r] <= cfg_conn_i;
        wts_q[r]  <= cfg_weights_i;
        leak_q[r] <= cfg_leak_i;
        thr_q[r]  <= cfg_thr_i;
        pot_q[r]  <= cfg_pot_i;
      end else if (wb_en_i && wb_idx_i == IDX_W'(r)) begin
        pot_q[r]  <= wb_pot_i;
      end
    end
  end

  assign rd_conn_o    = conn_q[rd_idx_i];
  assign rd_weights_o = wts_q[rd_idx_i];
  assign rd_leak_o    = leak_q[rd_idx_i];
  assign rd_thr_o     = thr_q[rd_idx_i];
  assign rd_pot_o     = pot_q[rd_idx_i];
endmodule

// File: rtl/snn_seq_ctrl.sv
module snn_seq_ctrl
  import snn_tile_pkg::*;
#(
  parameter int N_NEURONS = 256,
  parameter int N_INPUTS  = 256,
  localparam int IDX_W = $clog2(N_NEURONS),
  localparam int IN_W  = $clog2(N_INPUTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic             accept_o,
  output logic             acc_en_o,
  output logic             fin_o,
  output logic             last_o,
  output logic             busy_o,
  output logic [IDX_W-1:0] nrn_o,
  output logic [IN_W-1:0]  inp_o
);
  seq_st_e          st_q;
  logic [IDX_W-1:0] n_q;
  logic [IN_W-1:0]  j_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      n_q  <= '0;
      j_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (tick_i) begin
          st_q <= ST_ACC;
          n_q  <= '0;
          j_q  <= '0;
        end
        ST_ACC: begin
          if (j_q == IN_W'(N_INPUTS - 1)) st_q <= ST_FIN;
          else                            j_q  <= j_q + 1'b1;
        end
        ST_FIN: begin
          j_q <= '0;
          if (n_q == IDX_W'(N_NEURONS - 1)) begin
            st_q <= ST_IDLE;
          end else begin
            n_q  <= n_q + 1'b1;
            st_q <= ST_ACC;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign accept_o = (st_q == ST_IDLE) && tick_i;
  assign acc_en_o = (st_q == ST_ACC);
  assign fin_o    = (st_q == ST_FIN);
  assign last_o   = (n_q == IDX_W'(N_NEURONS - 1));
  assign busy_o   = (st_q != ST_IDLE);
  assign nrn_o    = n_q;
  assign inp_o    = j_q;
endmodule

// File: rtl/snn_accum.sv
module snn_accum
  import snn_tile_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             first_i,
  input  logic             active_i,
  input  logic [WGT_W-1:0] weight_i,
  input  pot_t             base_i,
  output pot_t             acc_o
);
  pot_t                    acc_q;
  pot_t                    seed;
  pot_t                    addend;
  logic signed [WGT_W-1:0] w_s;

  always_comb begin
    w_s    = weight_i;
    addend = active_i ? pot_t'(w_s) : '0;
    seed   = first_i ? base_i : acc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= sat_add(seed, addend);
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/snn_fire_unit.sv
module snn_fire_unit
  import snn_tile_pkg::*;
(
  input  pot_t acc_i,
  input  pot_t leak_i,
  input  pot_t thr_i,
  output logic fire_o,
  output pot_t pot_o
);
  pot_t leaked;

  always_comb begin
    leaked = sat_sub(acc_i, leak_i);
    fire_o = (leaked >= thr_i);
    pot_o  = fire_o ? '0 : leaked;
  end
endmodule

// File: rtl/snn_tile_core.sv
module snn_tile_core
  import snn_tile_pkg::*;
#(
  parameter int N_NEURONS = 256,
  parameter int N_INPUTS  = 256,
  localparam int IDX_W = $clog2(N_NEURONS),
  localparam int IN_W  = $clog2(N_INPUTS),
  localparam int WV_W  = N_WSEL * WGT_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       tick_i,
  input  logic [N_INPUTS-1:0]        spikes_in_i,
  input  logic [WSEL_W*N_INPUTS-1:0] axon_type_i,
  input  logic                       cfg_we_i,
  input  logic [IDX_W-1:0]           cfg_idx_i,
  input  logic [N_INPUTS-1:0]        cfg_conn_i,
  input  logic [WV_W-1:0]            cfg_weights_i,
  input  logic [POT_W-1:0]           cfg_leak_i,
  input  logic [POT_W-1:0]           cfg_thr_i,
  input  logic [POT_W-1:0]           cfg_pot_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic [N_NEURONS-1:0]       spikes_o,
  output logic                       upd_valid_o,
  output logic [IDX_W-1:0]           upd_idx_o,
  output logic [POT_W-1:0]           upd_pot_o
);
  logic             accept, acc_en, fin, last, busy;
  logic [IDX_W-1:0] nrn;
  logic [IN_W-1:0]  inp;

  logic [N_INPUTS-1:0] row_conn;
  logic [WV_W-1:0]     row_wts;
  pot_t                row_leak, row_thr, row_pot;
  pot_t                acc, new_pot;
  logic                fire;

  logic [N_INPUTS-1:0]  spk_lat_q;
  logic [N_NEURONS-1:0] spk_out_q;
  logic                 done_q, upd_v_q;
  logic [IDX_W-1:0]     upd_idx_q;
  pot_t                 upd_pot_q;

  logic [WSEL_W-1:0]    wsel;
  logic [WGT_W-1:0]     wsel_val;
  logic                 syn_active;

  snn_seq_ctrl #(.N_NEURONS(N_NEURONS), .N_INPUTS(N_INPUTS)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .accept_o (accept),
    .acc_en_o (acc_en),
    .fin_o    (fin),
    .last_o   (last),
    .busy_o   (busy),
    .nrn_o    (nrn),
    .inp_o    (inp)
  );

  snn_param_store #(.N_NEURONS(N_NEURONS), .N_INPUTS(N_INPUTS)) u_store (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cfg_we_i      (cfg_we_i & ~busy),
    .cfg_idx_i     (cfg_idx_i),
    .cfg_conn_i    (cfg_conn_i),
    .cfg_weights_i (cfg_weights_i),
    .cfg_leak_i    (pot_t'(cfg_leak_i)),
    .cfg_thr_i     (pot_t'(cfg_thr_i)),
    .cfg_pot_i     (pot_t'(cfg_pot_i)),
    .wb_en_i       (fin),
    .wb_idx_i      (nrn),
    .wb_pot_i      (new_pot),
    .rd_idx_i      (nrn),
    .rd_conn_o     (row_conn),
    .rd_weights_o  (row_wts),
    .rd_leak_o     (row_leak),
    .rd_thr_o      (row_thr),
    .rd_pot_o      (row_pot)
  );

  // synapse select: mask AND captured spike, weight picked by line type
  always_comb begin
    syn_active = row_conn[inp] & spk_lat_q[inp];
    wsel       = axon_type_i[WSEL_W*inp +: WSEL_W];
    wsel_val   = row_wts[WGT_W*wsel +: WGT_W];
  end

  snn_accum u_accum (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (acc_en),
    .first_i  (inp == '0),
    .active_i (syn_active),
    .weight_i (wsel_val),
    .base_i   (row_pot),
    .acc_o    (acc)
  );

  snn_fire_unit u_fire (
    .acc_i  (acc),
    .leak_i (row_leak),
    .thr_i  (row_thr),
    .fire_o (fire),
    .pot_o  (new_pot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spk_lat_q <= '0;
      spk_out_q <= '0;
      done_q    <= 1'b0;
      upd_v_q   <= 1'b0;
      upd_idx_q <= '0;
      upd_pot_q <= '0;
    end else begin
      done_q  <= fin & last;
      upd_v_q <= fin;
      if (accept) begin
        spk_lat_q <= spikes_in_i;
        spk_out_q <= '0;
      end
      if (fin) begin
        spk_out_q[nrn] <= fire;
        upd_idx_q      <= nrn;
        upd_pot_q      <= new_pot;
      end
    end
  end

  assign busy_o      = busy;
  assign done_o      = done_q;
  assign spikes_o    = spk_out_q;
  assign upd_valid_o = upd_v_q;
  assign upd_idx_o   = upd_idx_q;
  assign upd_pot_o   = upd_pot_q;
endmodule

// File: rtl/snn_tile_core_chk.sv
module snn_tile_core_chk #(
  parameter int N_NEURONS = 256,
  parameter int N_INPUTS  = 256,
  localparam int IDX_W = $clog2(N_NEURONS)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 tick_i,
  input logic                 busy_o,
  input logic                 done_o,
  input logic [N_NEURONS-1:0] spikes_o,
  input logic                 upd_valid_o,
  input logic [IDX_W-1:0]     upd_idx_o,
  input logic [15:0]          upd_pot_o
);
  // R3
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  // R3
  done_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (upd_valid_o && upd_idx_o == IDX_W'(N_NEURONS - 1)));

  // R3
  upd_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_o |=> !upd_valid_o);

  // R7
  fire_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_o && spikes_o[upd_idx_o]) |-> (upd_pot_o == '0));

  // R2
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(tick_i) && spikes_o == '0));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !tick_i) |=> $stable(spikes_o));
endmodule

bind snn_tile_core snn_tile_core_chk #(.N_NEURONS(N_NEURONS), .N_INPUTS(N_INPUTS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .spikes_o    (spikes_o),
  .upd_valid_o (upd_valid_o),
  .upd_idx_o   (upd_idx_o),
  .upd_pot_o   (upd_pot_o)
);

// File: tb/snn_tile_core_bench.sv
module snn_tile_core_bench;
  localparam int N   = 4;
  localparam int NI  = 8;
  localparam int IW  = $clog2(N);
  localparam int CPN = NI + 1;
  localparam int TOT = N * CPN;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [NI-1:0]   spikes_in = '0;
  logic [2*NI-1:0] axon_type = '0;
  logic            cfg_we = 1'b0;
  logic [IW-1:0]   cfg_idx = '0;
  logic [NI-1:0]   cfg_conn = '0;
  logic [35:0]     cfg_weights = '0;
  logic [15:0]     cfg_leak = '0, cfg_thr = '0, cfg_pot = '0;
  logic            busy, done, upd_valid;
  logic [N-1:0]    spikes;
  logic [IW-1:0]   upd_idx;
  logic [15:0]     upd_pot;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [NI-1:0] m_conn [N];
  int m_w [N][4];
  int m_leak [N], m_thr [N], m_pot [N];
  int m_type [NI];
  string pot_tag [N];

  always #10 clk = ~clk;

  snn_tile_core #(.N_NEURONS(N), .N_INPUTS(NI)) u_snn_tile_core (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .spikes_in_i(spikes_in),
    .axon_type_i(axon_type), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
    .cfg_conn_i(cfg_conn), .cfg_weights_i(cfg_weights), .cfg_leak_i(cfg_leak),
    .cfg_thr_i(cfg_thr), .cfg_pot_i(cfg_pot), .busy_o(busy), .done_o(done),
    .spikes_o(spikes), .upd_valid_o(upd_valid), .upd_idx_o(upd_idx), .upd_pot_o(upd_pot)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic set_types(input bit rnd);
    for (int j = 0; j < NI; j++) begin
      m_type[j] = rnd ? int'($urandom_range(0, 3)) : (j % 4);
      axon_type[2*j +: 2] = 2'(m_type[j]);
    end
  endtask

  task automatic cfg_row(input int n, input logic [NI-1:0] c, input int w0, input int w1,
                         input int w2, input int w3, input int lk, input int th, input int p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IW'(n); cfg_conn = c;
    cfg_weights = {9'(w3), 9'(w2), 9'(w1), 9'(w0)};
    cfg_leak = 16'(lk); cfg_thr = 16'(th); cfg_pot = 16'(p);
    @(negedge clk);
    cfg_we = 1'b0;
    m_conn[n] = c; m_w[n][0] = w0; m_w[n][1] = w1; m_w[n][2] = w2; m_w[n][3] = w3;
    m_leak[n] = lk; m_thr[n] = th; m_pot[n] = p;
  endtask

  // mode 0: clean, 1: tick + spike change mid-pass, 2: row write mid-pass
  task automatic run_tick(input logic [NI-1:0] spk, input int mode);
    int rp [N];
    bit rf [N];
    int cnt;
    logic [N-1:0] exp_spk;
    for (int n = 0; n < N; n++) begin
      int p = m_pot[n];
      for (int j = 0; j < NI; j++)
        if (m_conn[n][j] && spk[j]) p = sat(p + m_w[n][m_type[j]]);
      p = sat(p - m_leak[n]);
      rf[n] = (p >= m_thr[n]);
      rp[n] = rf[n] ? 0 : p;
    end
    @(negedge clk);
    spikes_in = spk; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    for (int k = 0; k <= TOT + 2; k++) begin
      cnt = k / CPN;
      if (cnt > N) cnt = N;
      for (int n = 0; n < N; n++) exp_spk[n] = rf[n] && (n < cnt);
      chk("R3", "busy_o", busy, k < TOT);
      chk("R3", "done_o", done, k == TOT);
      chk("R3", "upd_valid_o", upd_valid, (k >= CPN) && (k % CPN == 0) && (k <= TOT));
      if ((k >= CPN) && (k % CPN == 0) && (k <= TOT)) begin
        chk("R3", "upd_idx_o", upd_idx, k / CPN - 1);
        chk(pot_tag[k/CPN-1], "upd_pot_o", longint'($signed(upd_pot)), rp[k/CPN-1]);
      end
      chk(k > TOT ? "R9" : "R7", "spikes_o", spikes, exp_spk);
      if (mode == 1 && k == 3) begin tick = 1'b1; spikes_in = ~spk; end
      if (mode == 2 && k == 3) begin
        cfg_we = 1'b1; cfg_idx = '0; cfg_conn = '1; cfg_weights = '1;
        cfg_leak = 16'd0; cfg_thr = 16'h8000; cfg_pot = 16'h1234;
      end
      if (k == 4) begin tick = 1'b0; cfg_we = 1'b0; end
      if (k < TOT + 2) @(negedge clk);
    end
    for (int n = 0; n < N; n++) m_pot[n] = rp[n];
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < N; n++) begin
      m_conn[n] = '0; m_leak[n] = 0; m_thr[n] = 0; m_pot[n] = 0;
      for (int k = 0; k < 4; k++) m_w[n][k] = 0;
    end
    set_types(0);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy_o", busy, 0);
    chk("R1", "done_o", done, 0);
    chk("R1", "upd_valid_o", upd_valid, 0);
    chk("R1", "spikes_o", spikes, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "spikes_o after release", spikes, 0);

    // R4 mixed weights and types, R6 unconnected neuron, R5 both rails
    cfg_row(0, 8'hFF, 10, 20, -5, 3, 2, 100, 0);
    cfg_row(1, 8'h00, 99, 99, 99, 99, 7, 44, 50);
    cfg_row(2, 8'hFF, 255, 255, 255, 255, 1, 32767, 32700);
    cfg_row(3, 8'hFF, -256, -256, -256, -256, 0, 0, -32700);
    pot_tag[0] = "R4"; pot_tag[1] = "R6"; pot_tag[2] = "R5"; pot_tag[3] = "R5";
    run_tick(8'hFF, 0);
    run_tick(8'b1011_0110, 0);

    // R2 tick and input change while busy are ignored
    for (int n = 0; n < N; n++) pot_tag[n] = "R2";
    run_tick(8'hA5, 1);

    // R8 row write while busy is ignored
    for (int n = 0; n < N; n++) pot_tag[n] = "R8";
    run_tick(8'h3C, 2);

    // R7 equality fires and resets
    cfg_row(0, 8'h01, 10, 0, 0, 0, 0, 10, 0);
    cfg_row(1, 8'h02, 0, 7, 0, 0, 0, 8, 0);
    for (int n = 0; n < N; n++) pot_tag[n] = "R7";
    run_tick(8'h03, 0);

    // R9 spikes hold while idle
    repeat (5) begin
      @(negedge clk);
      chk("R9", "spikes_o idle", spikes, {2'b00, 1'b0, 1'b1} | (spikes & 4'b1100));
    end

    // R4 random rows and types
    for (int it = 0; it < 8; it++) begin
      set_types(1);
      for (int n = 0; n < N; n++) begin
        cfg_row(n, NI'($urandom()),
                int'($urandom_range(0, 511)) - 256, int'($urandom_range(0, 511)) - 256,
                int'($urandom_range(0, 511)) - 256, int'($urandom_range(0, 511)) - 256,
                int'($urandom_range(0, 40)), int'($urandom_range(0, 400)) - 100,
                int'($urandom_range(0, 600)) - 300);
        pot_tag[n] = "R4";
      end
      run_tick(NI'($urandom()), 0);
      run_tick(NI'($urandom()), 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule